// File: doc/BRIEF.md
# Prescaled Pulse-Density Modulator

This block turns an 8-bit duty value into a one-bit pulse-density stream that can drive the switch transistor of a boost converter. A first-order accumulator advances once per modulator step. On each step it adds the duty value, and the carry out of that addition becomes the output level for the whole step. Over a full cycle of 256 steps, the number of high steps equals the duty value, so a duty of 128 gives a 50% density.

A programmable 8-bit divider sets how many system clocks each step lasts, from 1 clock up to 256 clocks. This sets the shortest pulse the output can produce, so the pulse width can be matched to the inductor's charge time. At an 80 MHz system clock, a divider value of 255 gives steps of 3.2 µs.

The duty and divider values are written through a shared data bus with a write strobe and a select line. A new value reaches the modulator only at the next step boundary, so a step in progress is never shortened. The enable input holds the output low and clears the modulator while it is low.

Top module: `sd_pulse_gen`

## Requirements
- R1: While reset is held and in the first clocks after reset, `pulse_o` is low. Both stored values reset to zero.
- R2: While `en_i` is low, `pulse_o` is low from the next clock edge onward. The accumulator and the step counter return to zero.
- R3: With divider value P in effect, one modulator step lasts exactly P+1 clocks. With P = 0 the modulator steps on every clock.
- R4: On each step the accumulator adds the duty value modulo 256. `pulse_o` takes the carry of that addition and holds it unchanged until the next step.
- R5: With a fixed duty value D and divider value P, any window of 256·(P+1) consecutive clocks in steady state holds exactly D·(P+1) high clocks on `pulse_o`. D = 128 gives half.
- R6: A write with `we_i` high stores `wdata_i` as the duty value when `wsel_i` = 0, and as the divider value when `wsel_i` = 1. The stored value takes effect at the next step boundary, or at once while disabled. The current step keeps its length and level.
- R7: A divider write restarts the step counter from zero and leaves the accumulator unchanged.
- R8: A duty value of 0 never drives `pulse_o` high. A duty value of 255 gives 255 high steps in every 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Modulator enable; low forces the output low |
| we_i | input | 1 | Write strobe for the stored values |
| wsel_i | input | 1 | Write target: 0 duty, 1 divider |
| wdata_i | input | 8 | Write data |
| pulse_o | output | 1 | Pulse-density output |

## Verification
`pulse_o` is registered, so every effect of a step decided in one clock cycle appears one edge later. Disabling the block drives the output low after exactly one edge. A written value needs one edge to be stored and shows on the output one edge after the next step boundary. The bench follows each cycle with its own step model, which advances at the same rising edges, and compares at the falling edge, halfway between updates. The directed checks measure high-time and run length over whole 256-step periods and whole pulses, so they do not depend on the phase of the step counter.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic {
    SEL_DUTY = 1'b0,
    SEL_DIV  = 1'b1
  } wsel_e;
endpackage

// File: rtl/sd_rst_sync.sv
module sd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sd_cfg_regs.sv
module sd_cfg_regs #(
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned WD_W  = (DUTY_W > DIV_W) ? DUTY_W : DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic              wsel_i,
  input  logic [WD_W-1:0]   wdata_i,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic [DIV_W-1:0]  div_act_o
);
  logic [DUTY_W-1:0] duty_sh_q, duty_sh_d, duty_act_q, duty_act_d;
  logic [DIV_W-1:0]  div_sh_q,  div_sh_d,  div_act_q,  div_act_d;
  logic              load_act;

  assign load_act = !en_i || tick_i;

  always_comb begin
    duty_sh_d  = duty_sh_q;
    div_sh_d   = div_sh_q;
    duty_act_d = duty_act_q;
    div_act_d  = div_act_q;
    if (we_i && (wsel_i == sd_pkg::SEL_DUTY)) duty_sh_d = wdata_i[DUTY_W-1:0];
    if (we_i && (wsel_i == sd_pkg::SEL_DIV))  div_sh_d  = wdata_i[DIV_W-1:0];
    if (load_act) begin
      duty_act_d = duty_sh_q;
      div_act_d  = div_sh_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_sh_q  <= '0;
      div_sh_q   <= '0;
      duty_act_q <= '0;
      div_act_q  <= '0;
    end else begin
      duty_sh_q  <= duty_sh_d;
      div_sh_q   <= div_sh_d;
      duty_act_q <= duty_act_d;
      div_act_q  <= div_act_d;
    end
  end

  assign duty_act_o = duty_act_q;
  assign div_act_o  = div_act_q;

  AST_ACT_HELD_MID_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(duty_act_q) && $stable(div_act_q))); // R6
endmodule

// File: rtl/sd_prescaler.sv
module sd_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_act_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == div_act_i);

  always_comb begin
    if (!en_i || tick_o || restart_i) cnt_d = '0;
    else                              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_CNT_WITHIN_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= div_act_i)); // R3
  AST_STEP_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0)); // R3
  AST_DIV_WRITE_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/sd_accum.sv
module sd_accum #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] duty_act_i,
  output logic              pulse_o
);
  logic [DUTY_W-1:0] acc_q, acc_d;
  logic              pulse_q, pulse_d;
  logic [DUTY_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, duty_act_i};

  always_comb begin
    acc_d   = acc_q;
    pulse_d = pulse_q;
    if (!en_i) begin
      acc_d   = '0;
      pulse_d = 1'b0;
    end else if (tick_i) begin
      acc_d   = sum[DUTY_W-1:0];
      pulse_d = sum[DUTY_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  AST_LOW_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pulse_q); // R2
  AST_LEVEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(pulse_q) && $stable(acc_q))); // R4
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (duty_act_i == '0)) |=> !pulse_q); // R8
endmodule

// File: rtl/sd_pulse_gen.sv
module sd_pulse_gen #(
  parameter int unsigned DUTY_W = sd_pkg::DATA_W,
  parameter int unsigned DIV_W  = sd_pkg::DATA_W,
  localparam int unsigned WD_W  = (DUTY_W > DIV_W) ? DUTY_W : DIV_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            we_i,
  input  logic            wsel_i,
  input  logic [WD_W-1:0] wdata_i,
  output logic            pulse_o
);
  logic              rst_n_sync;
  logic              tick;
  logic              div_restart;
  logic [DUTY_W-1:0] duty_act;
  logic [DIV_W-1:0]  div_act;

  assign div_restart = we_i && (wsel_i == sd_pkg::SEL_DIV);

  sd_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  sd_cfg_regs #(.DUTY_W(DUTY_W), .DIV_W(DIV_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .en_i       (en_i),
    .tick_i     (tick),
    .we_i       (we_i),
    .wsel_i     (wsel_i),
    .wdata_i    (wdata_i),
    .duty_act_o (duty_act),
    .div_act_o  (div_act)
  );

  sd_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .en_i      (en_i),
    .restart_i (div_restart),
    .div_act_i (div_act),
    .tick_o    (tick)
  );

  sd_accum #(.DUTY_W(DUTY_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .en_i       (en_i),
    .tick_i     (tick),
    .duty_act_i (duty_act),
    .pulse_o    (pulse_o)
  );

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_n_sync |=> !pulse_o); // R1
endmodule

// File: tb/sd_pulse_gen_test.sv
module sd_pulse_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       we = 1'b0;
  logic       wsel = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       pulse;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          model_on = 1'b0;
  bit          done = 1'b0;

  logic [7:0] m_duty_sh, m_div_sh, m_duty_a, m_div_a, m_cnt, m_acc;
  logic       m_pulse;

  always #10 clk = ~clk;

  sd_pulse_gen uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .we_i    (we),
    .wsel_i  (wsel),
    .wdata_i (wdata),
    .pulse_o (pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] add9(input logic [7:0] a, input logic [7:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // Spec model of step timing, accumulation and write latching (R3 R4 R6 R7)
  always @(posedge clk) begin
    logic       t;
    logic [8:0] s;
    if (!model_on) begin
      m_duty_sh = 0; m_div_sh = 0; m_duty_a = 0; m_div_a = 0;
      m_cnt = 0; m_acc = 0; m_pulse = 0;
    end else begin
      t = en && (m_cnt == m_div_a);
      s = add9(m_acc, m_duty_a);
      if (!en) begin m_acc = 0; m_pulse = 0; end
      else if (t) begin m_acc = s[7:0]; m_pulse = s[8]; end
      if (!en || t || (we && wsel)) m_cnt = 0; else m_cnt = m_cnt + 8'd1;
      if (!en || t) begin m_duty_a = m_duty_sh; m_div_a = m_div_sh; end
      if (we && !wsel) m_duty_sh = wdata;
      if (we && wsel)  m_div_sh = wdata;
    end
  end

  always @(negedge clk) begin
    if (model_on && !done)
      check(pulse === m_pulse, "R4 R6 R7 cycle model", int'(pulse), int'(m_pulse));
  end

  task automatic drive(input bit e, input bit w, input bit s, input logic [7:0] d);
    @(negedge clk);
    en = e; we = w; wsel = s; wdata = d;
  endtask

  task automatic setup(input logic [7:0] duty, input logic [7:0] div);
    drive(1'b0, 1'b1, 1'b0, duty);
    drive(1'b0, 1'b1, 1'b1, div);
    drive(1'b0, 1'b0, 1'b0, 8'd0);
    drive(1'b1, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic density(input logic [7:0] duty, input logic [7:0] div, input string tag);
    int unsigned hi = 0;
    int unsigned win = 256 * (int'(div) + 1);
    setup(duty, div);
    repeat (2 * (int'(div) + 1) + 4) @(negedge clk);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pulse) hi++;
    end
    check(hi == int'(duty) * (int'(div) + 1), tag, hi, int'(duty) * (int'(div) + 1));
  endtask

  task automatic run_len(input logic [7:0] div, input string tag);
    int unsigned n = 0;
    bit prev = 1'b1;
    setup(8'd128, div);
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (!prev && pulse) break;
      prev = pulse;
    end
    n = 1;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (!pulse) break;
      n++;
    end
    check(n == int'(div) + 1, tag, n, int'(div) + 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(pulse === 1'b0, "R1 low in reset", int'(pulse), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    repeat (5) @(negedge clk);
    check(pulse === 1'b0, "R1 low after reset", int'(pulse), 0);
    // R1: stored duty resets to zero, so enabling without writes stays low
    drive(1'b1, 1'b0, 1'b0, 8'd0);
    repeat (20) @(negedge clk);
    check(pulse === 1'b0, "R1 zero duty after reset", int'(pulse), 0);

    density(8'd128, 8'd0, "R5 duty 128 div 0");
    density(8'd128, 8'd3, "R5 duty 128 div 3");
    density(8'd37,  8'd5, "R5 duty 37 div 5");
    density(8'd0,   8'd2, "R8 duty 0");
    density(8'd255, 8'd1, "R8 duty 255");
    density(8'd64,  8'd255, "R3 R5 div 255");
    run_len(8'd3, "R3 pulse width div 3");
    run_len(8'd0, "R3 pulse width div 0");
    run_len(8'd17, "R3 pulse width div 17");

    // R2: disable while high
    setup(8'd255, 8'd9);
    for (int g = 0; g < 100 && !pulse; g++) @(negedge clk);
    check(pulse === 1'b1, "R2 high before disable", int'(pulse), 1);
    drive(1'b0, 1'b0, 1'b0, 8'd0);
    @(negedge clk);
    check(pulse === 1'b0, "R2 low after disable", int'(pulse), 0);

    // R6: duty write mid-step does not alter the current level
    setup(8'd255, 8'd20);
    for (int g = 0; g < 100 && !pulse; g++) @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 8'd0);
    drive(1'b1, 1'b0, 1'b0, 8'd0);
    repeat (5) @(negedge clk);
    check(pulse === 1'b1, "R6 level kept mid-step", int'(pulse), 1);

    // Constrained random mix, checked by the cycle model (R6 R7)
    for (int i = 0; i < 20000; i++) begin
      bit e = ($urandom % 100) < 96;
      bit w = ($urandom % 100) < 4;
      bit s = $urandom % 2;
      logic [7:0] d = s ? (($urandom % 10 == 0) ? 8'($urandom) : 8'($urandom % 6))
                        : 8'($urandom);
      drive(e, w, s, d);
    end
    drive(1'b0, 1'b0, 1'b0, 8'd0);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule